// File: doc/BRIEF.md
# Operand Select Stage with Two-Level Result Forwarding

This block sits at the crossbar/issue slot of an in-order pipeline whose stages are fetch, decode with register read, operand select and issue, two execute stages, a result crossbar and register write. Each stage takes one clock. For each of the two source operands of the instruction presented to it, the block picks the freshest copy of the value. It looks first at the result that is on the result crossbar in this cycle. Next it looks at the result that was written back one cycle earlier, which a late-forward register keeps. Last it takes the value the register file returned at decode.

The block follows the destination tag of every issued instruction through both execute stages and the result crossbar stage. While a source's producer is still in an execute stage, it holds the instruction by keeping `issue_valid` low. The result crossbar gathers the outputs of an add/subtract unit, a shifter and a logic unit, using the unit code that travels with the tag. The selected result goes into the late-forward register. That register also drives the register-file write port.

The register file must show, on `rf_a` and `rf_b`, every write that was presented on the write port in an earlier cycle. An upstream stage that sees `issue_valid` low must keep the same instruction on the inputs in the next cycle.

Top module: `opsel_stage`

## Requirements
- R1: After reset no forwarding entry is valid. `wb_vld` is 0, and a first instruction takes both operands from the register file (source code 0).
- R2: When the result crossbar carries a valid result whose destination index equals a source index, that operand is the crossbar result and its source code is 2.
- R3: When the late-forward register holds a valid result for the source index and the crossbar does not, the operand is the late-forward value and its source code is 1.
- R4: When neither forwarding source matches, the operand is the register-file input and its source code is 0.
- R5: When both the crossbar and the late-forward register match one index, the crossbar value (the younger result) wins.
- R6: `issue_valid` is low while any source's producer is in execute stage 1 or 2. A held cycle sends no instruction down the tag pipeline.
- R7: A dependent instruction presented in the cycle after its producer issued is held for exactly two cycles. It then issues with the operand taken from the crossbar.
- R8: A result on the crossbar in cycle t appears on the write port (`wb_vld`, `wb_idx`, `wb_data`) in cycle t+1. The crossbar takes the unit chosen by the instruction's unit code: 0 add, 1 shift left by the low 6 bits of operand b, 2 bitwise exclusive-or.
- R9: The two operands are resolved independently, so in one cycle they may come from different sources.
- R10: An instruction issued with `in_wr` low creates no forwarding entry and no write, and it never holds a later reader of its destination index.
- R11: `issue_valid` is low whenever `in_vld` is low, and high for a valid instruction that has no pending producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | An instruction is at operand select |
| in_wr | input | 1 | The instruction writes its destination |
| in_unit | input | 2 | Execute unit code: 0 add, 1 shift, 2 logic |
| in_dst | input | 6 | Destination register index |
| in_src_a | input | 6 | Source index of operand a |
| in_src_b | input | 6 | Source index of operand b |
| rf_a | input | 64 | Register-file value for operand a |
| rf_b | input | 64 | Register-file value for operand b |
| res_add | input | 64 | Add/subtract unit output, result crossbar stage |
| res_shf | input | 64 | Shifter output, result crossbar stage |
| res_log | input | 64 | Logic unit output, result crossbar stage |
| issue_valid | output | 1 | Instruction issues in this cycle |
| op_a | output | 64 | Selected operand a |
| op_b | output | 64 | Selected operand b |
| op_a_src | output | 2 | Source of operand a: 0 register file, 1 late-forward, 2 crossbar |
| op_b_src | output | 2 | Source of operand b, same coding |
| wb_vld | output | 1 | Register-file write enable |
| wb_idx | output | 6 | Register-file write index |
| wb_data | output | 64 | Register-file write data |

## Verification
The operand outputs and `issue_valid` depend combinationally on the inputs of the current cycle and the tag pipeline, so the bench reads them in the same cycle it drives an instruction. It drives at the falling edge and samples 4 ns later, before the next rising edge. An instruction issued in cycle c occupies execute stage 1 in c+1 and stage 2 in c+2. It needs its unit result on the crossbar ports in c+3, shows on the write port in c+4, and is in the modelled register file from c+5. The bench keeps its own three-deep record of issued instructions on that schedule. From that record it derives the expected hold, source code and write-port contents for every cycle. Each operand is compared with an architectural register model that the bench updates in program order.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_LF   = 2'd1,
    SRC_XBAR = 2'd2
  } src_e;

  // youngest available copy wins: crossbar over late-forward over register file
  function automatic src_e pick_src(input logic xr_hit, input logic lf_hit);
    if (xr_hit)      return SRC_XBAR;
    else if (lf_hit) return SRC_LF;
    else             return SRC_RF;
  endfunction

  // producer still computing: no source can supply the value yet
  function automatic logic must_hold(input logic ex1_hit, input logic ex2_hit);
    return ex1_hit | ex2_hit;
  endfunction

endpackage

// File: rtl/opsel_tagpipe.sv
module opsel_tagpipe #(
  parameter int AW = 6,
  parameter int UW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          in_wr,
  input  logic [AW-1:0] in_dst,
  input  logic [UW-1:0] in_unit,
  output logic          ex1_vld,
  output logic [AW-1:0] ex1_dst,
  output logic          ex2_vld,
  output logic [AW-1:0] ex2_dst,
  output logic          xr_vld,
  output logic [AW-1:0] xr_dst,
  output logic [UW-1:0] xr_unit
);
  // stage 0 = execute 1, stage 1 = execute 2, stage 2 = result crossbar
  localparam int NSTG = 3;

  logic [NSTG-1:0] stg_vld;
  logic [AW-1:0]   stg_dst  [NSTG];
  logic [UW-1:0]   stg_unit [NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld[0]  <= 1'b0;
      stg_dst[0]  <= '0;
      stg_unit[0] <= '0;
    end else begin
      stg_vld[0]  <= issue & in_wr;
      stg_dst[0]  <= in_dst;
      stg_unit[0] <= in_unit;
    end
  end

  for (genvar k = 1; k < NSTG; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_vld[k]  <= 1'b0;
        stg_dst[k]  <= '0;
        stg_unit[k] <= '0;
      end else begin
        stg_vld[k]  <= stg_vld[k-1];
        stg_dst[k]  <= stg_dst[k-1];
        stg_unit[k] <= stg_unit[k-1];
      end
    end
  end

  assign ex1_vld = stg_vld[0];
  assign ex1_dst = stg_dst[0];
  assign ex2_vld = stg_vld[1];
  assign ex2_dst = stg_dst[1];
  assign xr_vld  = stg_vld[2];
  assign xr_dst  = stg_dst[2];
  assign xr_unit = stg_unit[2];

  // R6: a held cycle leaves a bubble in execute stage 1
  p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !ex1_vld);

  // R10: only writing instructions occupy the tag pipeline
  p_ex1_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (ex1_vld == $past(in_wr)));

endmodule

// File: rtl/opsel_resxbar.sv
module opsel_resxbar #(
  parameter int DW    = 64,
  parameter int AW    = 6,
  parameter int NUNIT = 3,
  parameter int UW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUNIT-1:0][DW-1:0]  res_bus,
  input  logic                      xr_vld,
  input  logic [AW-1:0]             xr_dst,
  input  logic [UW-1:0]             xr_unit,
  output logic [DW-1:0]             xr_data,
  output logic                      lf_vld,
  output logic [AW-1:0]             lf_dst,
  output logic [DW-1:0]             lf_data
);

  always_comb begin
    xr_data = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (xr_unit == UW'(u)) xr_data = res_bus[u];
    end
  end

  // late-forward register: also the register-file write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_vld  <= 1'b0;
      lf_dst  <= '0;
      lf_data <= '0;
    end else begin
      lf_vld  <= xr_vld;
      lf_dst  <= xr_dst;
      lf_data <= xr_data;
    end
  end

  // R8: crossbar result reaches the write port one cycle later
  p_wb_after_xr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xr_vld |=> (lf_vld && lf_dst == $past(xr_dst) && lf_data == $past(xr_data)));

  // R1: a valid write entry only ever comes from a crossbar result
  p_lf_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lf_vld |-> $past(xr_vld));

endmodule

// File: rtl/opsel_srcmux.sv
module opsel_srcmux
  import opsel_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_idx,
  input  logic [DW-1:0] rf_data,
  input  logic          xr_vld,
  input  logic [AW-1:0] xr_dst,
  input  logic [DW-1:0] xr_data,
  input  logic          lf_vld,
  input  logic [AW-1:0] lf_dst,
  input  logic [DW-1:0] lf_data,
  input  logic          ex1_vld,
  input  logic [AW-1:0] ex1_dst,
  input  logic          ex2_vld,
  input  logic [AW-1:0] ex2_dst,
  output logic [DW-1:0] op,
  output src_e          src_sel,
  output logic          pend
);

  function automatic logic tag_hit(input logic v, input logic [AW-1:0] tag,
                                   input logic [AW-1:0] idx);
    return v && (tag == idx);
  endfunction

  logic xr_hit, lf_hit, ex1_hit, ex2_hit;

  assign xr_hit  = tag_hit(xr_vld,  xr_dst,  src_idx);
  assign lf_hit  = tag_hit(lf_vld,  lf_dst,  src_idx);
  assign ex1_hit = tag_hit(ex1_vld, ex1_dst, src_idx);
  assign ex2_hit = tag_hit(ex2_vld, ex2_dst, src_idx);

  assign src_sel = pick_src(xr_hit, lf_hit);
  assign pend    = must_hold(ex1_hit, ex2_hit);

  always_comb begin
    case (src_sel)
      SRC_XBAR: op = xr_data;
      SRC_LF:   op = lf_data;
      default:  op = rf_data;
    endcase
  end

  // R2: a crossbar match delivers the crossbar value
  p_xbar_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xr_hit |-> (op == xr_data));

  // R5: with both forwarding sources matching, the younger one is used
  p_prio_xbar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xr_hit && lf_hit) |-> (src_sel == SRC_XBAR && op == xr_data));

  // R3: late-forward match without a crossbar match
  p_lf_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_hit && !xr_hit) |-> (op == lf_data && src_sel == SRC_LF));

  // R4: no forwarding match falls back to the register file
  p_rf_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lf_hit && !xr_hit) |-> (op == rf_data && src_sel == SRC_RF));

endmodule

// File: rtl/opsel_stage.sv
module opsel_stage
  import opsel_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 6,
  parameter int UW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_wr,
  input  logic [UW-1:0] in_unit,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [DW-1:0] res_add,
  input  logic [DW-1:0] res_shf,
  input  logic [DW-1:0] res_log,
  output logic          issue_valid,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [1:0]    op_a_src,
  output logic [1:0]    op_b_src,
  output logic          wb_vld,
  output logic [AW-1:0] wb_idx,
  output logic [DW-1:0] wb_data
);
  localparam int NOPS  = 2;
  localparam int NUNIT = 3;

  // named internal events
  logic                     ex1_vld, ex2_vld, xr_vld, lf_vld;
  logic [AW-1:0]            ex1_dst, ex2_dst, xr_dst, lf_dst;
  logic [UW-1:0]            xr_unit;
  logic [DW-1:0]            xr_data, lf_data;
  logic [NUNIT-1:0][DW-1:0] res_bus;
  logic [AW-1:0]            src_idx [NOPS];
  logic [DW-1:0]            rf_val  [NOPS];
  logic [DW-1:0]            op_val  [NOPS];
  src_e                     src_sel [NOPS];
  logic [NOPS-1:0]          pend;
  logic                     hold;

  assign res_bus[0] = res_add;
  assign res_bus[1] = res_shf;
  assign res_bus[2] = res_log;

  assign src_idx[0] = in_src_a;
  assign src_idx[1] = in_src_b;
  assign rf_val[0]  = rf_a;
  assign rf_val[1]  = rf_b;

  assign hold        = |pend;
  assign issue_valid = in_vld & ~hold;

  opsel_tagpipe #(.AW(AW), .UW(UW)) u_tags (
    .clk(clk), .rst_n(rst_n), .issue(issue_valid), .in_wr(in_wr),
    .in_dst(in_dst), .in_unit(in_unit),
    .ex1_vld(ex1_vld), .ex1_dst(ex1_dst), .ex2_vld(ex2_vld), .ex2_dst(ex2_dst),
    .xr_vld(xr_vld), .xr_dst(xr_dst), .xr_unit(xr_unit)
  );

  opsel_resxbar #(.DW(DW), .AW(AW), .NUNIT(NUNIT), .UW(UW)) u_resx (
    .clk(clk), .rst_n(rst_n), .res_bus(res_bus),
    .xr_vld(xr_vld), .xr_dst(xr_dst), .xr_unit(xr_unit), .xr_data(xr_data),
    .lf_vld(lf_vld), .lf_dst(lf_dst), .lf_data(lf_data)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    opsel_srcmux #(.DW(DW), .AW(AW)) u_mux (
      .clk(clk), .rst_n(rst_n), .src_idx(src_idx[g]), .rf_data(rf_val[g]),
      .xr_vld(xr_vld), .xr_dst(xr_dst), .xr_data(xr_data),
      .lf_vld(lf_vld), .lf_dst(lf_dst), .lf_data(lf_data),
      .ex1_vld(ex1_vld), .ex1_dst(ex1_dst), .ex2_vld(ex2_vld), .ex2_dst(ex2_dst),
      .op(op_val[g]), .src_sel(src_sel[g]), .pend(pend[g])
    );
  end

  assign op_a     = op_val[0];
  assign op_b     = op_val[1];
  assign op_a_src = src_sel[0];
  assign op_b_src = src_sel[1];

  assign wb_vld  = lf_vld;
  assign wb_idx  = lf_dst;
  assign wb_data = lf_data;

  // R11: nothing issues without a presented instruction
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> !issue_valid);

  // R6: an issued instruction has no operand whose producer is in execute
  p_no_early_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !((ex1_vld && (ex1_dst == in_src_a || ex1_dst == in_src_b)) ||
                      (ex2_vld && (ex2_dst == in_src_a || ex2_dst == in_src_b))));

endmodule

// File: tb/tb_opsel_stage.sv
module tb_opsel_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_wr;
  logic [1:0]  in_unit;
  logic [5:0]  in_dst, in_src_a, in_src_b;
  logic [63:0] rf_a, rf_b, res_add, res_shf, res_log;
  logic        issue_valid, wb_vld;
  logic [63:0] op_a, op_b, wb_data;
  logic [1:0]  op_a_src, op_b_src;
  logic [5:0]  wb_idx;

  always #10 clk = ~clk;  // 50 MHz

  opsel_stage dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_wr(in_wr), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .rf_a(rf_a), .rf_b(rf_b), .res_add(res_add), .res_shf(res_shf), .res_log(res_log),
    .issue_valid(issue_valid), .op_a(op_a), .op_b(op_b),
    .op_a_src(op_a_src), .op_b_src(op_b_src),
    .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [63:0] rfm  [64];  // physical register file model
  logic [63:0] arch [64];  // program-order values
  logic        pv [4];
  logic [5:0]  pd [4];
  logic [1:0]  pu [4];
  logic [63:0] pr [4];
  logic        lf_v;
  logic [5:0]  lf_r;
  logic [63:0] lf_d;
  logic [1:0]  last_sa, last_sb;

  function automatic logic [63:0] eu(input logic [1:0] u, input logic [63:0] a,
                                     input logic [63:0] b);
    case (u)
      2'd0:    return a + b;
      2'd1:    return a << b[5:0];
      default: return a ^ b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_src(input logic [5:0] s);
    if (pv[3] && pd[3] == s) return 2'd2;
    if (lf_v && lf_r == s)   return 2'd1;
    return 2'd0;
  endfunction

  function automatic string src_req(input logic [5:0] s);
    if (pv[3] && pd[3] == s && lf_v && lf_r == s) return "R5";
    case (exp_src(s))
      2'd2:    return "R2";
      2'd1:    return "R3";
      default: return "R4";
    endcase
  endfunction

  // one clock: drive at the falling edge, sample 4 ns later
  task automatic cyc(input logic v, input logic w, input logic [1:0] u,
                     input logic [5:0] d, input logic [5:0] sa, input logic [5:0] sb,
                     output logic iss);
    logic hold_e;
    logic [63:0] r;
    @(negedge clk);
    lf_v = pv[3]; lf_r = pd[3]; lf_d = pr[3];
    for (int k = 3; k > 0; k--) begin
      pv[k] = pv[k-1]; pd[k] = pd[k-1]; pu[k] = pu[k-1]; pr[k] = pr[k-1];
    end
    pv[0] = 1'b0;
    res_add = (pv[3] && pu[3] == 2'd0) ? pr[3] : ~pr[3];
    res_shf = (pv[3] && pu[3] == 2'd1) ? pr[3] : pr[3] ^ 64'h00FF_00FF_00FF_00FF;
    res_log = (pv[3] && pu[3] == 2'd2) ? pr[3] : pr[3] + 64'd1;
    in_vld = v; in_wr = w; in_unit = u; in_dst = d; in_src_a = sa; in_src_b = sb;
    rf_a = rfm[sa]; rf_b = rfm[sb];
    #4;
    // R8: write port carries last cycle's crossbar result
    chk(wb_vld == lf_v, "R8 wb_vld", {63'd0, wb_vld}, {63'd0, lf_v});
    if (lf_v) begin
      chk(wb_idx == lf_r, "R8 wb_idx", {58'd0, wb_idx}, {58'd0, lf_r});
      chk(wb_data == lf_d, "R8 wb_data", wb_data, lf_d);
      rfm[lf_r] = lf_d;
    end
    hold_e = (pv[1] && (pd[1] == sa || pd[1] == sb)) ||
             (pv[2] && (pd[2] == sa || pd[2] == sb));
    iss = v && !hold_e;
    chk(issue_valid == iss, v ? "R6 issue_valid" : "R11 issue_valid",
        {63'd0, issue_valid}, {63'd0, iss});
    last_sa = op_a_src; last_sb = op_b_src;
    if (iss) begin
      chk(op_a_src == exp_src(sa), src_req(sa), {62'd0, op_a_src}, {62'd0, exp_src(sa)});
      chk(op_b_src == exp_src(sb), src_req(sb), {62'd0, op_b_src}, {62'd0, exp_src(sb)});
      chk(op_a == arch[sa], src_req(sa), op_a, arch[sa]);
      chk(op_b == arch[sb], src_req(sb), op_b, arch[sb]);
      r = eu(u, arch[sa], arch[sb]);
      pv[0] = w; pd[0] = d; pu[0] = u; pr[0] = r;
      if (w) arch[d] = r;
    end
  endtask

  task automatic nop(input int n);
    logic i;
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 2'd0, 6'd0, 6'd0, 6'd0, i);
  endtask

  task automatic instr(input logic w, input logic [1:0] u, input logic [5:0] d,
                       input logic [5:0] sa, input logic [5:0] sb, output int stalls);
    logic i;
    stalls = 0;
    cyc(1'b1, w, u, d, sa, sb, i);
    while (!i && stalls < 10) begin
      stalls++;
      cyc(1'b1, w, u, d, sa, sb, i);
    end
  endtask

  task automatic t_reset;
    int s;
    chk(wb_vld == 1'b0, "R1 wb_vld after reset", {63'd0, wb_vld}, 64'd0);
    nop(1);
    instr(1'b1, 2'd0, 6'd20, 6'd1, 6'd2, s);
    chk(last_sa == 2'd0 && last_sb == 2'd0, "R1 first sources",
        {62'd0, last_sa}, 64'd0);
    nop(5);
  endtask

  task automatic t_back2back;
    int s;
    instr(1'b1, 2'd0, 6'd3, 6'd1, 6'd2, s);
    instr(1'b1, 2'd0, 6'd5, 6'd3, 6'd4, s);
    chk(s == 2, "R7 stall count", 64'(s), 64'd2);
    chk(last_sa == 2'd2, "R7 crossbar source", {62'd0, last_sa}, 64'd2);
    nop(5);
  endtask

  task automatic t_gaps;
    int s;
    // two idle cycles: crossbar
    instr(1'b1, 2'd0, 6'd6, 6'd1, 6'd2, s);
    nop(2);
    instr(1'b1, 2'd0, 6'd7, 6'd6, 6'd1, s);
    chk(s == 0 && last_sa == 2'd2, "R2 direct bypass", {62'd0, last_sa}, 64'd2);
    nop(5);
    // three idle cycles: late-forward register
    instr(1'b1, 2'd0, 6'd8, 6'd2, 6'd3, s);
    nop(3);
    instr(1'b1, 2'd0, 6'd9, 6'd1, 6'd8, s);
    chk(s == 0 && last_sb == 2'd1, "R3 late forward", {62'd0, last_sb}, 64'd1);
    nop(5);
    // four idle cycles: register file
    instr(1'b1, 2'd0, 6'd10, 6'd4, 6'd5, s);
    nop(4);
    instr(1'b1, 2'd0, 6'd11, 6'd10, 6'd10, s);
    chk(s == 0 && last_sa == 2'd0 && last_sb == 2'd0, "R4 register file",
        {62'd0, last_sa}, 64'd0);
    nop(5);
  endtask

  task automatic t_prio;
    int s;
    instr(1'b1, 2'd0, 6'd12, 6'd1, 6'd2, s);
    instr(1'b1, 2'd2, 6'd12, 6'd3, 6'd4, s);
    nop(2);
    instr(1'b1, 2'd0, 6'd13, 6'd12, 6'd1, s);
    chk(s == 0 && last_sa == 2'd2, "R5 younger wins", {62'd0, last_sa}, 64'd2);
    nop(5);
  endtask

  task automatic t_split;
    int s;
    instr(1'b1, 2'd0, 6'd14, 6'd1, 6'd2, s);
    instr(1'b1, 2'd1, 6'd15, 6'd3, 6'd4, s);
    nop(2);
    instr(1'b1, 2'd2, 6'd16, 6'd14, 6'd15, s);
    chk(s == 0 && last_sa == 2'd1 && last_sb == 2'd2, "R9 independent operands",
        {60'd0, last_sa, last_sb}, {60'd0, 2'd1, 2'd2});
    nop(5);
  endtask

  task automatic t_units;
    int s;
    // R8: shift and logic results travel through the crossbar
    instr(1'b1, 2'd1, 6'd17, 6'd5, 6'd2, s);
    nop(2);
    instr(1'b1, 2'd2, 6'd18, 6'd17, 6'd6, s);
    nop(2);
    instr(1'b1, 2'd1, 6'd19, 6'd18, 6'd17, s);
    chk(s == 0 && last_sa == 2'd2, "R8 unit result path", {62'd0, last_sa}, 64'd2);
    nop(5);
  endtask

  task automatic t_nowrite;
    int s;
    instr(1'b0, 2'd0, 6'd21, 6'd1, 6'd2, s);
    instr(1'b1, 2'd0, 6'd22, 6'd21, 6'd21, s);
    chk(s == 0, "R10 no hold on unwritten dest", 64'(s), 64'd0);
    nop(3);
    chk(last_sa == 2'd0, "R10 source stays register file", {62'd0, last_sa}, 64'd0);
    nop(3);
  endtask

  task automatic t_stream;
    int s;
    logic [15:0] lfsr = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) nop(1);
      else instr(lfsr[3] | lfsr[4], 2'(lfsr[6:5] % 3), {4'd0, lfsr[8:7]},
                 {4'd0, lfsr[10:9]}, {4'd0, lfsr[12:11]}, s);
    end
    nop(6);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      rfm[i]  = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
      arch[i] = rfm[i];
    end
    for (int k = 0; k < 4; k++) begin
      pv[k] = 1'b0; pd[k] = '0; pu[k] = '0; pr[k] = '0;
    end
    lf_v = 1'b0; lf_r = '0; lf_d = '0;
    in_vld = 0; in_wr = 0; in_unit = 0; in_dst = 0; in_src_a = 0; in_src_b = 0;
    rf_a = 0; rf_b = 0; res_add = 0; res_shf = 0; res_log = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #4;
    chk(wb_vld == 1'b0 && issue_valid == 1'b0, "R1 reset outputs",
        {62'd0, wb_vld, issue_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_back2back();
    t_gaps();
    t_prio();
    t_split();
    t_units();
    t_nowrite();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule